// File: doc/BRIEF.md
# Per-CPU Interrupt Frame Decoder

This block decodes register-bus accesses aimed at a row of per-CPU interrupt register regions. The regions sit back to back from a fixed base address, and each CPU owns 128 KB of it. The lower 64 KB of a region is a control frame. It holds an identification window and a read-only type register that reports the CPU's index, whether it is the last populated CPU, and its packed affinity. The upper 64 KB is a private-interrupt frame. It holds enable, pending, priority and trigger-configuration state for that CPU's 32 private interrupts.

The target CPU comes from the address, not from the requester. Any master can therefore program any CPU's private interrupts. A CPU-count input sets how many regions are populated. Accesses past the last populated region, or below the base, are not claimed. They return zero and change nothing.

Requests arrive on a valid/ready channel and each produces exactly one response on a valid/ready channel. Back-pressure works as follows. While a response is waiting, `req_ready` stays low and no new request is taken. A held response keeps its data and hit flag unchanged until `rsp_ready` is seen.

Top module: `pcpu_frame_decoder`

## Requirements
- R1: The CPU index of an access is (req_addr − BASE_ADDR) / 0x20000. An access is claimed (rsp_hit=1) only when req_addr ≥ BASE_ADDR, the index is below cpu_count and the index is below NCPU. An unclaimed access returns rsp_hit=0 and rsp_rdata=0, and its write changes no state.
- R2: Within a claimed region, offset bit 16 selects the frame: 1 selects the private-interrupt frame and 0 selects the control frame. A register offset of one frame has no meaning in the other.
- R3: In the control frame, the words at 0x0000 (control) and 0x0014 (wake) read zero and ignore writes. So does every other offset that no requirement names, in either frame.
- R4: The word at control offset 0x0008 is read-only. It reads the CPU index in bits [15:8], and bit 4 is set only when index = cpu_count − 1.
- R5: The word at control offset 0x000C is read-only. It reads that CPU's 32-bit packed affinity, taken from cpu_aff[index*32 +: 32].
- R6: Control offsets 0xFFD0 to 0xFFFC read zero, except 0xFFE8, which reads 0x0000003B. Writes there are ignored.
- R7: Private offset 0x100 sets enable bits where the write data is 1, and 0x180 clears them where the write data is 1. Both read the current 32-bit enable mask, with bit n standing for interrupt n.
- R8: Private offset 0x200 sets pending bits where the write data is 1, and 0x280 clears them where the write data is 1. Both read the current 32-bit pending mask.
- R9: Private offsets 0x400 to 0x41C are eight read/write priority words. Byte k of word w is the priority of interrupt 4w+k.
- R10: Private offsets 0xC00 and 0xC04 are two read/write configuration words, with 2 bits per interrupt (interrupt n at word n/16, bits 2(n%16)+1:2(n%16)).
- R11: Private offsets 0x080, 0x300, 0x380, 0xD00 and 0xE00 read zero and ignore writes.
- R12: After reset, every CPU's enable, pending, priority and configuration state is zero. Also after reset, rsp_valid is 0 and req_ready is 1.
- R13: A request is taken when req_valid && req_ready. Its response is valid on the next cycle. While rsp_valid && !rsp_ready, req_ready is 0 and rsp_rdata/rsp_hit hold steady. Write responses carry rsp_rdata=0.
- R14: State is kept per CPU. A write to one CPU's private frame leaves every other CPU's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Byte address (bits [1:0] ignored) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed this cycle when high with rsp_valid |
| rsp_hit | output | 1 | Access fell inside a populated region |
| rsp_rdata | output | 32 | Read data, zero for writes and misses |
| cpu_count | input | CNT_W | Number of populated regions |
| cpu_aff | input | NCPU*32 | Packed affinity word for each CPU |

## Verification
The bench builds the block with NCPU=4 and BASE_ADDR=0x2000_0000. It first drives cpu_count=3, so a fourth region exists in hardware but must not be claimed. It then raises cpu_count to 4, which shows the write that was refused earlier left no trace and that the last-CPU flag moves to index 3. A pseudo-random rsp_ready pattern holds responses back, which exercises the stall and stability rules while the set/clear, priority, configuration and cross-CPU scenarios run.

// File: rtl/pcpu_frame_pkg.sv
package pcpu_frame_pkg;
  localparam int NIRQ       = 32;
  localparam int CPU_SHIFT  = 17;
  localparam int FRAME_BIT  = 16;
  localparam int PRIO_WORDS = NIRQ / 4;
  localparam int CFG_WORDS  = NIRQ / 16;
  localparam int PIDX_W     = $clog2(PRIO_WORDS);
  localparam int CIDX_W     = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1;

  // private frame offsets
  localparam logic [15:0] OFF_EN_SET   = 16'h0100;
  localparam logic [15:0] OFF_EN_CLR   = 16'h0180;
  localparam logic [15:0] OFF_PND_SET  = 16'h0200;
  localparam logic [15:0] OFF_PND_CLR  = 16'h0280;
  localparam logic [15:0] OFF_PRIO     = 16'h0400;
  localparam logic [15:0] OFF_CFG      = 16'h0C00;
  // control frame offsets
  localparam logic [15:0] OFF_TYPE_LO  = 16'h0008;
  localparam logic [15:0] OFF_TYPE_HI  = 16'h000C;
  localparam logic [15:0] OFF_ID_ARCH  = 16'hFFE8;
  localparam logic [31:0] ID_ARCH_VAL  = 32'h0000_003B;
  localparam logic [31:0] LAST_FLAG    = 32'h0000_0010;

  typedef enum logic [1:0] {
    WR_NONE, WR_SET, WR_CLR
  } bitop_e;

  function automatic logic word_at(input logic [15:0] off, input logic [15:0] target);
    return off[15:2] == target[15:2];
  endfunction

  function automatic logic in_window(input logic [15:0] off, input logic [15:0] lo,
                                     input int unsigned bytes);
    return (32'(off) >= 32'(lo)) && (32'(off) < 32'(lo) + bytes);
  endfunction
endpackage

// File: rtl/pcpu_addr_decode.sv
module pcpu_addr_decode #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int NCPU = 4,
  localparam int IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int CNT_W = $clog2(NCPU + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cpu_count,
  output logic              hit,
  output logic              priv,
  output logic [15:0]       off,
  output logic [IDX_W-1:0]  cpu_idx,
  output logic              last
);
  import pcpu_frame_pkg::*;
  localparam int FIELD_W = ADDR_W - CPU_SHIFT;

  logic [ADDR_W-1:0]  rel;
  logic [FIELD_W-1:0] field;

  assign rel     = addr - BASE_ADDR;
  assign field   = rel[ADDR_W-1:CPU_SHIFT];
  assign off     = rel[15:0];
  assign priv    = rel[FRAME_BIT];
  assign cpu_idx = IDX_W'(field);
  assign hit     = (addr >= BASE_ADDR) && (field < FIELD_W'(cpu_count))
                   && (field < FIELD_W'(NCPU));
  assign last    = (CNT_W'(cpu_idx) + CNT_W'(1)) == cpu_count;
endmodule

// File: rtl/pcpu_irq_bank.sv
module pcpu_irq_bank
  import pcpu_frame_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] off,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);
  logic [NIRQ-1:0] en_q, pnd_q;
  logic [31:0]     prio_q [PRIO_WORDS];
  logic [31:0]     cfg_q  [CFG_WORDS];
  logic            prio_hit, cfg_hit;
  logic [PIDX_W-1:0] prio_idx;
  logic [CIDX_W-1:0] cfg_idx;
  bitop_e          en_op, pnd_op;

  assign prio_hit = in_window(off, OFF_PRIO, PRIO_WORDS * 4);
  assign cfg_hit  = in_window(off, OFF_CFG, CFG_WORDS * 4);
  assign prio_idx = PIDX_W'((off - OFF_PRIO) >> 2);
  assign cfg_idx  = CIDX_W'((off - OFF_CFG) >> 2);

  always_comb begin
    en_op  = WR_NONE;
    pnd_op = WR_NONE;
    if (wr_en) begin
      if (word_at(off, OFF_EN_SET))  en_op  = WR_SET;
      if (word_at(off, OFF_EN_CLR))  en_op  = WR_CLR;
      if (word_at(off, OFF_PND_SET)) pnd_op = WR_SET;
      if (word_at(off, OFF_PND_CLR)) pnd_op = WR_CLR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pnd_q <= '0;
    end else begin
      case (en_op)
        WR_SET:  en_q <= en_q | wr_data;
        WR_CLR:  en_q <= en_q & ~wr_data;
        default: en_q <= en_q;
      endcase
      case (pnd_op)
        WR_SET:  pnd_q <= pnd_q | wr_data;
        WR_CLR:  pnd_q <= pnd_q & ~wr_data;
        default: pnd_q <= pnd_q;
      endcase
    end
  end

  for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_q[w] <= '0;
      else if (wr_en && prio_hit && prio_idx == PIDX_W'(w)) prio_q[w] <= wr_data;
    end
  end

  for (genvar c = 0; c < CFG_WORDS; c++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[c] <= '0;
      else if (wr_en && cfg_hit && cfg_idx == CIDX_W'(c)) cfg_q[c] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (word_at(off, OFF_EN_SET) || word_at(off, OFF_EN_CLR))        rd_data = en_q;
    else if (word_at(off, OFF_PND_SET) || word_at(off, OFF_PND_CLR)) rd_data = pnd_q;
    else if (prio_hit)                                                rd_data = prio_q[prio_idx];
    else if (cfg_hit)                                                 rd_data = cfg_q[cfg_idx];
  end
endmodule

// File: rtl/pcpu_ctrl_read.sv
module pcpu_ctrl_read #(
  parameter int IDX_W = 2
) (
  input  logic [15:0]      off,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             last,
  input  logic [31:0]      aff,
  output logic [31:0]      rd_data
);
  import pcpu_frame_pkg::*;

  always_comb begin
    rd_data = '0;
    if (word_at(off, OFF_TYPE_LO))
      rd_data = (32'(cpu_idx) << 8) | (last ? LAST_FLAG : 32'h0);
    else if (word_at(off, OFF_TYPE_HI))
      rd_data = aff;
    else if (word_at(off, OFF_ID_ARCH))
      rd_data = ID_ARCH_VAL;
  end
endmodule

// File: rtl/pcpu_frame_decoder.sv
module pcpu_frame_decoder #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0800_0000,
  parameter int NCPU = 4,
  localparam int IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int CNT_W = $clog2(NCPU + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [31:0]       rsp_rdata,
  input  logic [CNT_W-1:0]  cpu_count,
  input  logic [NCPU*32-1:0] cpu_aff
);
  logic             fire, hit, priv, last;
  logic [15:0]      off;
  logic [IDX_W-1:0] cpu_idx;
  logic [31:0]      bank_rd [NCPU];
  logic [31:0]      ctrl_rd, rd_sel;

  assign req_ready = !rsp_valid;
  assign fire      = req_valid && req_ready;

  pcpu_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NCPU(NCPU)) u_dec (
    .addr(req_addr), .cpu_count(cpu_count), .hit(hit), .priv(priv),
    .off(off), .cpu_idx(cpu_idx), .last(last)
  );

  for (genvar g = 0; g < NCPU; g++) begin : g_bank
    pcpu_irq_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fire && req_write && hit && priv && cpu_idx == IDX_W'(g)),
      .off(off), .wr_data(req_wdata), .rd_data(bank_rd[g])
    );
  end

  pcpu_ctrl_read #(.IDX_W(IDX_W)) u_ctrl (
    .off(off), .cpu_idx(cpu_idx), .last(last),
    .aff(cpu_aff[cpu_idx*32 +: 32]), .rd_data(ctrl_rd)
  );

  always_comb begin
    rd_sel = '0;
    if (hit && !req_write) rd_sel = priv ? bank_rd[cpu_idx] : ctrl_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= hit;
      rsp_rdata <= rd_sel;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pcpu_frame_checker.sv
module pcpu_frame_checker #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int NCPU = 4,
  localparam int CNT_W = $clog2(NCPU + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [31:0]       rsp_rdata,
  input logic [CNT_W-1:0]  cpu_count
);
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_rdata == 32'h0); // R1

  AST_STALL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R13

  AST_STALL_HOLDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_hit)); // R13

  AST_ACCEPT_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R13

  AST_ID_ARCH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && cpu_count != '0
    && req_addr == BASE_ADDR + ADDR_W'(32'hFFE8) |=> rsp_rdata == 32'h0000_003B); // R6

  AST_SOLE_CPU_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && cpu_count == CNT_W'(1)
    && req_addr == BASE_ADDR + ADDR_W'(32'h0008) |=> rsp_rdata == 32'h0000_0010); // R4
endmodule

bind pcpu_frame_decoder pcpu_frame_checker #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NCPU(NCPU)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
  .cpu_count(cpu_count)
);

// File: tb/pcpu_frame_decoder_bench.sv
`timescale 1ns/1ps
module pcpu_frame_decoder_bench;
  localparam int NCPU = 4;
  localparam int CNT_W = $clog2(NCPU + 1);
  localparam logic [31:0] BASE = 32'h2000_0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, rsp_hit;
  logic [31:0] rsp_rdata;
  logic [CNT_W-1:0] cpu_count = CNT_W'(3);
  logic [NCPU*32-1:0] cpu_aff;
  int checks = 0, fails = 0;
  bit done = 0;

  logic        exp_hit_q [$];
  logic [31:0] exp_data_q [$];
  string       exp_tag_q [$];

  for (genvar c = 0; c < NCPU; c++) begin : g_aff
    assign cpu_aff[c*32 +: 32] = 32'h0102_0300 + 32'(c * 17);
  end

  always #2 clk = ~clk;

  pcpu_frame_decoder #(.ADDR_W(32), .BASE_ADDR(BASE), .NCPU(NCPU)) u_pcpu_frame_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_rdata(rsp_rdata), .cpu_count(cpu_count), .cpu_aff(cpu_aff)
  );

  function automatic logic [31:0] ad(input int cpu, input bit pf, input logic [15:0] off);
    return BASE + 32'(cpu) * 32'h2_0000 + (pf ? 32'h1_0000 : 32'h0) + 32'(off);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [31:0] a, input bit w, input logic [31:0] d,
                     input bit eh, input logic [31:0] ed, input string tag);
    @(negedge clk);
    req_addr = a; req_write = w; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_hit_q.push_back(eh);
    exp_data_q.push_back(w ? 32'h0 : ed);
    exp_tag_q.push_back(tag);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input string tag);
    acc(a, 1'b1, d, 1'b1, 32'h0, tag);
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string tag);
    acc(a, 1'b0, 32'h0, 1'b1, e, tag);
  endtask

  task automatic drain();
    while (exp_hit_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // response back-pressure pattern
  initial begin
    logic [4:0] lfsr;
    lfsr = 5'h13;
    forever begin
      @(posedge clk);
      lfsr = {lfsr[3:0], lfsr[4] ^ lfsr[2]};
      #1 rsp_ready = lfsr[0] | lfsr[1];
    end
  end

  // scoreboard monitor
  initial begin
    logic prev_stall, prev_hit;
    logic [31:0] prev_data;
    logic eh;
    logic [31:0] ed;
    string tg;
    prev_stall = 1'b0; prev_hit = 1'b0; prev_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall)
          check(rsp_valid && !req_ready && rsp_rdata == prev_data && rsp_hit == prev_hit,
                "R13 stalled response must hold", rsp_rdata, prev_data);
        prev_stall = rsp_valid && !rsp_ready;
        prev_data  = rsp_rdata;
        prev_hit   = rsp_hit;
        if (rsp_valid && rsp_ready) begin
          if (exp_hit_q.size() == 0) begin
            check(1'b0, "R13 unexpected response", rsp_rdata, 32'h0);
          end else begin
            eh = exp_hit_q.pop_front();
            ed = exp_data_q.pop_front();
            tg = exp_tag_q.pop_front();
            check(rsp_hit == eh && rsp_rdata == ed, tg, {rsp_hit, rsp_rdata[30:0]}, {eh, ed[30:0]});
            if (rsp_rdata != ed) $display("  (%s full data %h vs %h)", tg, rsp_rdata, ed);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R12 idle after reset", {req_ready, rsp_valid}, 32'h2);
    rd(ad(0, 1, 16'h0100), 32'h0, "R12 enable cleared");
    rd(ad(1, 1, 16'h0200), 32'h0, "R12 pending cleared");
    rd(ad(1, 1, 16'h0400), 32'h0, "R12 priority cleared");
    rd(ad(2, 1, 16'h0C04), 32'h0, "R12 config cleared");

    rd(ad(0, 0, 16'h0008), 32'h0000_0000, "R4 type cpu0");
    rd(ad(1, 0, 16'h0008), 32'h0000_0100, "R4 type cpu1");
    rd(ad(2, 0, 16'h0008), 32'h0000_0210, "R4 type cpu2 last");
    rd(ad(1, 0, 16'h000C), 32'h0102_0311, "R5 affinity cpu1");
    rd(ad(2, 0, 16'h000C), 32'h0102_0322, "R5 affinity cpu2");
    wr(ad(1, 0, 16'h0008), 32'hFFFF_FFFF, "R4 type write");
    rd(ad(1, 0, 16'h0008), 32'h0000_0100, "R4 type unchanged");

    rd(ad(0, 0, 16'hFFE8), 32'h0000_003B, "R6 arch id");
    rd(ad(2, 0, 16'hFFE8), 32'h0000_003B, "R6 arch id cpu2");
    rd(ad(0, 0, 16'hFFD0), 32'h0, "R6 id low");
    rd(ad(0, 0, 16'hFFFC), 32'h0, "R6 id high");

    wr(ad(0, 0, 16'h0000), 32'hFFFF_FFFF, "R3 control write");
    rd(ad(0, 0, 16'h0000), 32'h0, "R3 control reads zero");
    wr(ad(0, 0, 16'h0014), 32'hFFFF_FFFF, "R3 wake write");
    rd(ad(0, 0, 16'h0014), 32'h0, "R3 wake reads zero");
    rd(ad(0, 0, 16'h0040), 32'h0, "R3 unmapped control");
    rd(ad(0, 1, 16'h0500), 32'h0, "R3 unmapped private");

    wr(ad(1, 1, 16'h0100), 32'h0000_00F0, "R7 set enable a");
    wr(ad(1, 1, 16'h0100), 32'h0000_0103, "R7 set enable b");
    rd(ad(1, 1, 16'h0180), 32'h0000_01F3, "R7 enable accumulates");
    wr(ad(1, 1, 16'h0180), 32'h0000_0030, "R7 clear enable");
    rd(ad(1, 1, 16'h0100), 32'h0000_01C3, "R7 enable after clear");
    rd(ad(0, 1, 16'h0100), 32'h0, "R14 cpu0 enable untouched");
    rd(ad(2, 1, 16'h0100), 32'h0, "R14 cpu2 enable untouched");
    rd(ad(1, 0, 16'h0100), 32'h0, "R2 control frame has no enable");
    rd(ad(1, 1, 16'h0008), 32'h0, "R2 private frame has no type");

    wr(ad(2, 1, 16'h0200), 32'h8000_0001, "R8 set pending");
    wr(ad(2, 1, 16'h0280), 32'h0000_0001, "R8 clear pending");
    rd(ad(2, 1, 16'h0200), 32'h8000_0000, "R8 pending result");
    rd(ad(1, 1, 16'h0280), 32'h0, "R14 cpu1 pending untouched");

    wr(ad(0, 1, 16'h041C), 32'hA0B0_C0D0, "R9 priority write");
    wr(ad(0, 1, 16'h0400), 32'h1122_3344, "R9 priority write first");
    rd(ad(0, 1, 16'h041C), 32'hA0B0_C0D0, "R9 priority top word");
    rd(ad(0, 1, 16'h0400), 32'h1122_3344, "R9 priority first word");
    rd(ad(0, 1, 16'h0418), 32'h0, "R9 neighbour word");
    rd(ad(1, 1, 16'h041C), 32'h0, "R14 cpu1 priority untouched");

    wr(ad(1, 1, 16'h0C04), 32'h5555_AAAA, "R10 config write");
    rd(ad(1, 1, 16'h0C04), 32'h5555_AAAA, "R10 config readback");
    rd(ad(1, 1, 16'h0C00), 32'h0, "R10 other config word");

    wr(ad(0, 1, 16'h0080), 32'hFFFF_FFFF, "R11 group write");
    rd(ad(0, 1, 16'h0080), 32'h0, "R11 group zero");
    wr(ad(0, 1, 16'h0300), 32'hFFFF_FFFF, "R11 active write");
    rd(ad(0, 1, 16'h0300), 32'h0, "R11 active set zero");
    rd(ad(0, 1, 16'h0380), 32'h0, "R11 active clear zero");
    rd(ad(0, 1, 16'h0D00), 32'h0, "R11 modifier zero");
    rd(ad(0, 1, 16'h0E00), 32'h0, "R11 access ctrl zero");

    acc(ad(3, 1, 16'h0100), 1'b1, 32'h0000_FFFF, 1'b0, 32'h0, "R1 write past count");
    acc(ad(3, 1, 16'h0100), 1'b0, 32'h0, 1'b0, 32'h0, "R1 read past count");
    acc(ad(3, 0, 16'hFFE8), 1'b0, 32'h0, 1'b0, 32'h0, "R1 id past count");
    acc(BASE - 32'h4, 1'b0, 32'h0, 1'b0, 32'h0, "R1 below base");
    drain();
    cpu_count = CNT_W'(4);
    @(negedge clk);
    rd(ad(3, 1, 16'h0100), 32'h0, "R1 refused write left no state");
    rd(ad(3, 0, 16'h0008), 32'h0000_0310, "R4 last moved to cpu3");
    rd(ad(2, 0, 16'h0008), 32'h0000_0200, "R4 cpu2 no longer last");
    acc(ad(4, 0, 16'h0008), 1'b0, 32'h0, 1'b0, 32'h0, "R1 beyond array");
    rd(ad(1, 1, 16'h0100), 32'h0000_01C3, "R14 cpu1 state kept");
    drain();
    finish_run();
  end
endmodule